// File: doc/BRIEF.md
# DMA Destination Address Stepper and Acknowledge Driver

This block holds the per-channel control state of a four-channel DMA engine. For every channel it keeps the running destination address, a two-bit destination mode, and two acknowledge settings: which half of a dual-address transfer carries the acknowledge strobe, and the strobe's polarity. Each time a transfer finishes on a channel, that channel's destination address moves by a step. The step depends on the mode and on the transfer size, which is byte, word, longword or a 16-byte burst.

Settings that cannot be honoured leave the address where it was and set a sticky per-channel configuration-error flag. A second sticky per-channel flag reports a fixed destination used with a 16-byte burst into the X/Y memory region. The acknowledge outputs follow the bus phase indicators combinationally for the channel that owns the bus. Only the lower channels can change the acknowledge phase and polarity. The upper channels always acknowledge in the read half, active-low.

Top module: `dma_dest_ack_ctrl`

## Requirements
- R1: After reset, every destination address, mode field, acknowledge setting and error flag is 0, and every `ack_o` bit is 1 (inactive, active-low).
- R2: With `reg_sel`=0 the control word of channel `reg_ch` is written and read in this layout: bits [1:0] destination mode, bit 4 acknowledge phase (0 read half, 1 write half), bit 5 acknowledge level (0 active-low, 1 active-high). All other bits read 0. With `reg_sel`=1 the 32-bit destination address is written and read.
- R3: With mode 00 (fixed), a transfer-done pulse leaves the destination address unchanged.
- R4: With mode 01 (increment), a transfer-done pulse adds 1, 2, 4 or 16 for size codes 00, 01, 10 and 11 respectively, wrapping modulo 2^32.
- R5: With mode 10 (decrement), a transfer-done pulse subtracts 1, 2 or 4 for size codes 00, 01 and 10, wrapping modulo 2^32.
- R6: A transfer-done pulse with mode 11, or with mode 10 and size code 11, leaves the address unchanged and sets that channel's `cfg_err_o` bit. The bit stays set until reset.
- R7: A transfer-done pulse with mode 00, size code 11 and `xfer_xy`=1 sets that channel's sticky `xy_err_o` bit. The same pulse with `xfer_xy`=0, or with any other mode, does not set it.
- R8: `ack_o[c]` is in its active state exactly in the cycles where `bus_ch`=c and the phase indicator selected by channel c's phase bit (`rd_phase` or `wr_phase`) is high.
- R9: The active state of `ack_o[c]` is 0 when the level bit is 0 and 1 when it is 1. The idle state is the opposite value.
- R10: On channels 2 and 3, writes to the phase and level bits are ignored and those bits read 0. Their acknowledge therefore always uses the read half and is active-low.
- R11: A transfer-done pulse changes only the channel named by `xfer_ch`. An address write in the same cycle to the same channel takes precedence over the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the destination address |
| reg_ch | input | 2 | Channel addressed by the register port |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register (combinational) |
| xfer_done | input | 1 | One-cycle pulse marking a completed transfer |
| xfer_ch | input | 2 | Channel of the completed transfer |
| xfer_size | input | 2 | Transfer size code: 00 byte, 01 word, 10 longword, 11 16-byte burst |
| xfer_xy | input | 1 | Destination of the completed transfer lies in X/Y memory |
| bus_ch | input | 2 | Channel currently owning the bus |
| rd_phase | input | 1 | Read half of the dual-address transfer is in progress |
| wr_phase | input | 1 | Write half of the dual-address transfer is in progress |
| ack_o | output | 4 | Per-channel acknowledge strobes |
| cfg_err_o | output | 4 | Sticky per-channel illegal-configuration flags |
| xy_err_o | output | 4 | Sticky per-channel fixed-burst-to-X/Y flags |

## Verification
The bench targets the address wrap in both directions. A stepper that carries into a wider field, or that saturates, would show a wrong low word after stepping past 0xFFFFFFFF or below 0. It drives decrement with a burst size and the reserved mode. A design that treated these as legal would move the address by some arbitrary amount and leave the error flag clear. It writes the acknowledge bits on an upper channel and reads them back, to catch a design that stores them and lets them flip the strobe. It also issues an address write and a done pulse to one channel in the same cycle, which shows whether the step overrides the written value.

// File: rtl/dmadst_pkg.sv
package dmadst_pkg;

    typedef enum logic [1:0] {
        DM_FIXED = 2'b00,
        DM_INC   = 2'b01,
        DM_DEC   = 2'b10,
        DM_RSVD  = 2'b11
    } dst_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE    = 2'b00,
        SZ_WORD    = 2'b01,
        SZ_LONG    = 2'b10,
        SZ_BURST16 = 2'b11
    } xfer_size_e;

    // control word bit positions
    localparam int CTRL_MODE_LSB  = 0;
    localparam int CTRL_PHASE_BIT = 4;
    localparam int CTRL_LEVEL_BIT = 5;

    typedef struct packed {
        dst_mode_e mode;
        logic      ack_wr;   // 1: acknowledge in write half
        logic      ack_hi;   // 1: active-high acknowledge
        logic      cfg_err;
        logic      xy_err;
    } ch_ctrl_t;

endpackage

// File: rtl/dmadst_step.sv
module dmadst_step
    import dmadst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  dst_mode_e         mode_i,
    input  xfer_size_e        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              illegal_o
);
    localparam int STEP_W = 5;

    logic [STEP_W-1:0] step_bytes;

    always_comb begin
        unique case (size_i)
            SZ_BYTE:    step_bytes = STEP_W'(1);
            SZ_WORD:    step_bytes = STEP_W'(2);
            SZ_LONG:    step_bytes = STEP_W'(4);
            default:    step_bytes = STEP_W'(16);
        endcase
    end

    always_comb begin
        illegal_o = 1'b0;
        addr_o    = addr_i;
        unique case (mode_i)
            DM_FIXED: addr_o = addr_i;
            DM_INC:   addr_o = addr_i + ADDR_W'(step_bytes);
            DM_DEC: begin
                if (size_i == SZ_BURST16) illegal_o = 1'b1;
                else                      addr_o = addr_i - ADDR_W'(step_bytes);
            end
            default:  illegal_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/dmadst_ack.sv
module dmadst_ack (
    input  logic owner_i,
    input  logic rd_phase_i,
    input  logic wr_phase_i,
    input  logic ack_wr_i,
    input  logic ack_hi_i,
    output logic ack_o
);
    logic active;

    always_comb begin
        active = owner_i && (ack_wr_i ? wr_phase_i : rd_phase_i);
        ack_o  = ack_hi_i ? active : ~active;
    end

endmodule

// File: rtl/dma_dest_ack_ctrl.sv
module dma_dest_ack_ctrl
    import dmadst_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ACK_CH = 2,
    parameter int ADDR_W = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [CH_W-1:0]   reg_ch,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              xfer_done,
    input  logic [CH_W-1:0]   xfer_ch,
    input  logic [1:0]        xfer_size,
    input  logic              xfer_xy,
    input  logic [CH_W-1:0]   bus_ch,
    input  logic              rd_phase,
    input  logic              wr_phase,
    output logic [NUM_CH-1:0] ack_o,
    output logic [NUM_CH-1:0] cfg_err_o,
    output logic [NUM_CH-1:0] xy_err_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][ADDR_W-1:0] dst;
        ch_ctrl_t [NUM_CH-1:0]         ctl;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_CH-1:0][ADDR_W-1:0] step_addr;
    logic [NUM_CH-1:0]             step_illegal;
    logic [NUM_CH-1:0][ADDR_W-1:0] dst_vec;
    logic [NUM_CH-1:0][1:0]        mode_vec;
    logic [NUM_CH-1:0]             ackhi_vec;
    logic [NUM_CH-1:0]             ackwr_vec;

    xfer_size_e size_e;
    assign size_e = xfer_size_e'(xfer_size);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dmadst_step #(.ADDR_W(ADDR_W)) u_step (
            .mode_i    (state_q.ctl[g].mode),
            .size_i    (size_e),
            .addr_i    (state_q.dst[g]),
            .addr_o    (step_addr[g]),
            .illegal_o (step_illegal[g])
        );

        dmadst_ack u_ack (
            .owner_i    (bus_ch == CH_W'(g)),
            .rd_phase_i (rd_phase),
            .wr_phase_i (wr_phase),
            .ack_wr_i   (state_q.ctl[g].ack_wr),
            .ack_hi_i   (state_q.ctl[g].ack_hi),
            .ack_o      (ack_o[g])
        );

        assign dst_vec[g]   = state_q.dst[g];
        assign mode_vec[g]  = state_q.ctl[g].mode;
        assign ackhi_vec[g] = state_q.ctl[g].ack_hi;
        assign ackwr_vec[g] = state_q.ctl[g].ack_wr;
        assign cfg_err_o[g] = state_q.ctl[g].cfg_err;
        assign xy_err_o[g]  = state_q.ctl[g].xy_err;
    end

    // next-state computation
    always_comb begin
        state_d = state_q;
        for (int c = 0; c < NUM_CH; c++) begin
            // transfer completion first; a same-cycle register write overrides it
            if (xfer_done && xfer_ch == CH_W'(c)) begin
                if (step_illegal[c]) begin
                    state_d.ctl[c].cfg_err = 1'b1;
                end else begin
                    state_d.dst[c] = step_addr[c];
                end
                if (state_q.ctl[c].mode == DM_FIXED && size_e == SZ_BURST16 && xfer_xy) begin
                    state_d.ctl[c].xy_err = 1'b1;
                end
            end
            if (reg_we && reg_ch == CH_W'(c)) begin
                if (reg_sel) begin
                    state_d.dst[c] = reg_wdata;
                end else begin
                    state_d.ctl[c].mode = dst_mode_e'(reg_wdata[CTRL_MODE_LSB +: 2]);
                    if (c < ACK_CH) begin
                        state_d.ctl[c].ack_wr = reg_wdata[CTRL_PHASE_BIT];
                        state_d.ctl[c].ack_hi = reg_wdata[CTRL_LEVEL_BIT];
                    end else begin
                        state_d.ctl[c].ack_wr = 1'b0;
                        state_d.ctl[c].ack_hi = 1'b0;
                    end
                end
            end
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_ch == CH_W'(c)) begin
                if (reg_sel) begin
                    reg_rdata = state_q.dst[c];
                end else begin
                    reg_rdata[CTRL_MODE_LSB +: 2] = state_q.ctl[c].mode;
                    reg_rdata[CTRL_PHASE_BIT]     = state_q.ctl[c].ack_wr;
                    reg_rdata[CTRL_LEVEL_BIT]     = state_q.ctl[c].ack_hi;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/dmadst_checker.sv
module dmadst_checker #(
    parameter int NUM_CH = 4,
    parameter int ACK_CH = 2,
    parameter int ADDR_W = 32,
    parameter int CH_W   = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_we,
    input logic                          reg_sel,
    input logic [CH_W-1:0]               reg_ch,
    input logic                          xfer_done,
    input logic [CH_W-1:0]               xfer_ch,
    input logic [1:0]                    xfer_size,
    input logic [CH_W-1:0]               bus_ch,
    input logic                          rd_phase,
    input logic                          wr_phase,
    input logic [NUM_CH-1:0]             ack_o,
    input logic [NUM_CH-1:0]             cfg_err_o,
    input logic [NUM_CH-1:0]             xy_err_o,
    input logic [NUM_CH-1:0][ADDR_W-1:0] dst_vec,
    input logic [NUM_CH-1:0][1:0]        mode_vec,
    input logic [NUM_CH-1:0]             ackhi_vec,
    input logic [NUM_CH-1:0]             ackwr_vec
);
    logic no_addr_wr;
    logic [ADDR_W-1:0] inc_amt;

    assign no_addr_wr = !(reg_we && reg_sel && reg_ch == xfer_ch);
    assign inc_amt = (xfer_size == 2'b11) ? ADDR_W'(16) : (ADDR_W'(1) << xfer_size);

    // error flags never clear outside reset (R6, R7)
    p_cfg_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_err_o) & ~cfg_err_o) == '0);
    p_xy_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(xy_err_o) & ~xy_err_o) == '0);

    // illegal step holds address and raises the flag (R6)
    p_illegal_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && no_addr_wr &&
         (mode_vec[xfer_ch] == 2'b11 || (mode_vec[xfer_ch] == 2'b10 && xfer_size == 2'b11)))
        |=> (dst_vec[$past(xfer_ch)] == $past(dst_vec[xfer_ch])) && cfg_err_o[$past(xfer_ch)]);

    // fixed mode holds address (R3)
    p_fixed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && no_addr_wr && mode_vec[xfer_ch] == 2'b00)
        |=> dst_vec[$past(xfer_ch)] == $past(dst_vec[xfer_ch]));

    // increment advances by the size-dependent amount (R4)
    p_inc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && no_addr_wr && mode_vec[xfer_ch] == 2'b01)
        |=> dst_vec[$past(xfer_ch)] == $past(dst_vec[xfer_ch]) + $past(inc_amt));

    // no phase indicator: every strobe at its idle level (R9)
    p_ack_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_phase && !wr_phase) |-> ack_o == ~ackhi_vec);

    // at most one channel acknowledges at a time (R8)
    p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o ^ ~ackhi_vec));

    // upper channels never hold acknowledge settings (R10)
    for (genvar g = ACK_CH; g < NUM_CH; g++) begin : g_upper
        p_upper_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !ackhi_vec[g] && !ackwr_vec[g]);
    end

    logic unused_bus;
    assign unused_bus = ^bus_ch;

endmodule

bind dma_dest_ack_ctrl dmadst_checker #(
    .NUM_CH(NUM_CH), .ACK_CH(ACK_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_ch(reg_ch),
    .xfer_done(xfer_done), .xfer_ch(xfer_ch), .xfer_size(xfer_size),
    .bus_ch(bus_ch), .rd_phase(rd_phase), .wr_phase(wr_phase),
    .ack_o(ack_o), .cfg_err_o(cfg_err_o), .xy_err_o(xy_err_o),
    .dst_vec(dst_vec), .mode_vec(mode_vec), .ackhi_vec(ackhi_vec), .ackwr_vec(ackwr_vec)
);

// File: tb/dma_dest_ack_ctrl_test.sv
module dma_dest_ack_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we, reg_sel;
    logic [1:0]  reg_ch;
    logic [31:0] reg_wdata, reg_rdata;
    logic        xfer_done, xfer_xy;
    logic [1:0]  xfer_ch, xfer_size;
    logic [1:0]  bus_ch;
    logic        rd_phase, wr_phase;
    logic [3:0]  ack_o, cfg_err_o, xy_err_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dma_dest_ack_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_ch(reg_ch),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
        .xfer_ch(xfer_ch), .xfer_size(xfer_size), .xfer_xy(xfer_xy), .bus_ch(bus_ch),
        .rd_phase(rd_phase), .wr_phase(wr_phase), .ack_o(ack_o),
        .cfg_err_o(cfg_err_o), .xy_err_o(xy_err_o)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic [1:0]  mode;
        logic [1:0]  size;
        logic [31:0] start;
        logic [31:0] expd;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t TBL [NVEC] = '{
        '{2'd0, 2'd1, 2'd0, 32'h0000_0100, 32'h0000_0101},
        '{2'd1, 2'd1, 2'd1, 32'h0000_0100, 32'h0000_0102},
        '{2'd2, 2'd1, 2'd2, 32'h0000_0100, 32'h0000_0104},
        '{2'd3, 2'd1, 2'd3, 32'h0000_0100, 32'h0000_0110},
        '{2'd0, 2'd1, 2'd2, 32'hFFFF_FFFE, 32'h0000_0002},
        '{2'd1, 2'd2, 2'd0, 32'h0000_0100, 32'h0000_00FF},
        '{2'd2, 2'd2, 2'd1, 32'h0000_0100, 32'h0000_00FE},
        '{2'd3, 2'd2, 2'd2, 32'h0000_0002, 32'hFFFF_FFFE},
        '{2'd0, 2'd0, 2'd3, 32'h0000_1234, 32'h0000_1234},
        '{2'd1, 2'd0, 2'd1, 32'h0000_0055, 32'h0000_0055}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [1:0] ch, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_ch = ch; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic done(input logic [1:0] ch, input logic [1:0] sz, input logic xy);
        @(negedge clk);
        xfer_done = 1'b1; xfer_ch = ch; xfer_size = sz; xfer_xy = xy;
        @(negedge clk);
        xfer_done = 1'b0; xfer_xy = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [1:0] ch, output logic [31:0] d);
        reg_sel = sel; reg_ch = ch;
        #1 d = reg_rdata;
    endtask

    task automatic phase(input logic [1:0] ch, input logic r, input logic w);
        bus_ch = ch; rd_phase = r; wr_phase = w;
        #1;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; reg_we = 0; reg_sel = 0; reg_ch = 0; reg_wdata = 0;
        xfer_done = 0; xfer_ch = 0; xfer_size = 0; xfer_xy = 0;
        bus_ch = 0; rd_phase = 0; wr_phase = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ack idle", {28'd0, ack_o}, 32'hF);
        check("R1 cfg_err", {28'd0, cfg_err_o}, 32'h0);
        check("R1 xy_err", {28'd0, xy_err_o}, 32'h0);
        rd(1'b1, 2'd2, d); check("R1 dst", d, 32'h0);
        rd(1'b0, 2'd0, d); check("R1 ctrl", d, 32'h0);

        // R3/R4/R5 table
        for (int i = 0; i < NVEC; i++) begin
            wr(1'b1, TBL[i].ch, TBL[i].start);
            wr(1'b0, TBL[i].ch, {30'd0, TBL[i].mode});
            done(TBL[i].ch, TBL[i].size, 1'b0);
            rd(1'b1, TBL[i].ch, d);
            check(TBL[i].mode == 2'd0 ? "R3 fixed" : (TBL[i].mode == 2'd1 ? "R4 inc" : "R5 dec"),
                  d, TBL[i].expd);
        end
        check("R6 no flag on legal", {28'd0, cfg_err_o}, 32'h0);

        // R2 control layout, junk bits dropped
        wr(1'b0, 2'd1, 32'hFFFF_FFF2);
        rd(1'b0, 2'd1, d); check("R2 ctrl layout", d, 32'h0000_0032);

        // R10 upper channel ignores ack bits
        wr(1'b0, 2'd2, 32'h0000_0031);
        rd(1'b0, 2'd2, d); check("R10 ctrl readback", d, 32'h0000_0001);
        phase(2'd2, 1'b1, 1'b0); check("R10 ack read half low", {31'd0, ack_o[2]}, 32'h0);
        phase(2'd2, 1'b0, 1'b1); check("R10 ack write half idle", {31'd0, ack_o[2]}, 32'h1);

        // R8/R9 channel 0 write-half, active-high
        wr(1'b0, 2'd0, 32'h0000_0030);
        phase(2'd0, 1'b0, 1'b0); check("R9 idle low", {28'd0, ack_o}, 32'h4 | 32'h8 | 32'h0);
        phase(2'd0, 1'b0, 1'b1); check("R8 wr half active", {28'd0, ack_o}, 32'hD);
        phase(2'd0, 1'b1, 1'b0); check("R8 rd half ignored", {28'd0, ack_o}, 32'hC);
        phase(2'd1, 1'b0, 1'b1); check("R8 ch1 owns bus, wr half", {28'd0, ack_o}, 32'hE);
        phase(2'd1, 1'b1, 1'b0); check("R8 ch1 rd half idle", {28'd0, ack_o}, 32'hC);
        phase(2'd3, 1'b1, 1'b0); check("R9 ch3 active low", {28'd0, ack_o}, 32'h4);
        phase(2'd0, 1'b0, 1'b0);

        // R6 illegal settings
        wr(1'b1, 2'd0, 32'h40);
        wr(1'b0, 2'd0, 32'h3);
        done(2'd0, 2'd0, 1'b0);
        rd(1'b1, 2'd0, d); check("R6 rsvd holds addr", d, 32'h40);
        check("R6 flag ch0", {28'd0, cfg_err_o}, 32'h1);
        wr(1'b0, 2'd0, 32'h1);
        done(2'd0, 2'd0, 1'b0);
        rd(1'b1, 2'd0, d); check("R6 recover step", d, 32'h41);
        check("R6 sticky", {28'd0, cfg_err_o}, 32'h1);
        wr(1'b1, 2'd3, 32'h80);
        wr(1'b0, 2'd3, 32'h2);
        done(2'd3, 2'd3, 1'b0);
        rd(1'b1, 2'd3, d); check("R6 dec burst holds", d, 32'h80);
        check("R6 flag ch3", {28'd0, cfg_err_o}, 32'h9);

        // R7 X/Y hazard
        wr(1'b0, 2'd1, 32'h0);
        done(2'd1, 2'd3, 1'b0);
        check("R7 no xy flag", {28'd0, xy_err_o}, 32'h0);
        wr(1'b0, 2'd2, 32'h1);
        done(2'd2, 2'd3, 1'b1);
        check("R7 inc no flag", {28'd0, xy_err_o}, 32'h0);
        done(2'd1, 2'd3, 1'b1);
        check("R7 xy flag ch1", {28'd0, xy_err_o}, 32'h2);

        // R11 channel isolation and write priority
        wr(1'b1, 2'd2, 32'h10);
        done(2'd3, 2'd0, 1'b0);
        rd(1'b1, 2'd2, d); check("R11 other channel untouched", d, 32'h10);
        @(negedge clk);
        reg_we = 1; reg_sel = 1; reg_ch = 2'd2; reg_wdata = 32'h500;
        xfer_done = 1; xfer_ch = 2'd2; xfer_size = 2'd2;
        @(negedge clk);
        reg_we = 0; xfer_done = 0;
        rd(1'b1, 2'd2, d); check("R11 write wins", d, 32'h500);

        // R1 again after reset
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; #1;
        check("R1 flags cleared", {24'd0, cfg_err_o, xy_err_o}, 32'h0);

        finished = 1;
        summary();
        $finish;
    end

endmodule